// File: doc/BRIEF.md
# Multichannel Coincidence Trigger Controller

This block makes the trigger decisions for a sixteen-channel waveform-sampling front end. Each channel brings a digitized discriminator level, an enable, and a flag that says whether it takes part in the shared trigger decision. Every channel picks its own trigger source: its own discriminator edge, the shared (central) decision, or an external trigger line. The block answers with a one-cycle "stop sampling" pulse per channel and a per-channel dead flag. A release pulse from the conversion logic re-arms a channel. All delays are counted in cycles of the fast clock that runs the block.

The central decision counts the participating channels whose coincidence gate is open. It fires when that count reaches a programmable multiplicity of one, two or three. Four further modes shape the result. A channel can act as a master whose trigger fires a run of following channels in succession, spaced by a post-trigger delay. Neighbouring channels can be paired so that the second one captures a pulse while the first is busy. All channels can be held in a common dead time. An external second-level gate can veto every trigger.

Top module: `coinc_trig`

## Requirements
- R1: While reset is held and right after it, `trig` and `dead` are all zeros.
- R2: A channel with source code 0 (self) triggers on a rising discriminator edge when its `edge_fall` bit is 0, or on a falling edge when it is 1. The edge is seen by comparing `disc` with its value one clock earlier. `trig` for that channel is high for exactly one cycle, in the cycle after the edge is sampled.
- R3: A triggered channel shows `dead` high from the cycle its `trig` pulse is high. It stays dead until a cycle in which its `rel` bit is high, and is free in the following cycle. A trigger request for a dead channel is ignored: no pulse, and no later pulse from it.
- R4: A participating channel (enabled, `ct_part` set, not dead) that sees its discriminator edge opens its coincidence gate for `gate_len` cycles, the edge cycle included. A value of 0 counts as 1. The central event occurs in the cycle where the number of open gates first reaches the threshold set by `mult_sel`. Channels with source code 1 (central) trigger on that event. Two hits whose gates do not overlap never add up.
- R5: `mult_sel` = 0 needs at least one open gate, 1 needs at least two, and 2 or 3 needs at least three. At threshold three, two overlapping hits cause no trigger.
- R6: With `only_part` high, a central event triggers only those central-source channels whose own gate is open in that cycle.
- R7: A channel with source code 2 (external) triggers on a rising edge of `ext_trig`. While `ext_trig` stays high, it does not trigger again. Source code 3 never triggers from a request.
- R8: With `common_dead` high, every channel reads dead while any channel is busy. Requests in that time are ignored; only chain firing may still reach a channel that is not itself busy.
- R9: A channel with a nonzero 4-bit field N at `chain_len[4i+3:4i]` acts as a master. When it triggers while no chain is running, channels i+1 … i+N (modulo 16) are fired one by one. Successive pulses are `post_trig`+1 cycles apart, whatever their source setting. A slave is skipped if it is disabled or busy. Among masters firing together, the lowest index wins.
- R10: With `pp_en[k]` high, requests of channels 2k and 2k+1 are merged. The merged request goes to channel 2k if it is enabled and not dead, otherwise to channel 2k+1 if that one is, otherwise nowhere.
- R11: With `l2_en` high and `l2_gate` low, no trigger of any kind is produced and no channel becomes dead.
- R12: A channel whose `ch_en` bit is low never triggers and never opens a coincidence gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all delays counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc | input | 16 | Digitized discriminator level per channel |
| ch_en | input | 16 | Per-channel enable |
| ct_part | input | 16 | Channel takes part in the central decision |
| edge_fall | input | 16 | Edge select: 0 rising, 1 falling |
| src_sel | input | 32 | Source per channel, bits [2i+1:2i]: 0 self, 1 central, 2 external, 3 none |
| ext_trig | input | 1 | External trigger line, rising edge used |
| mult_sel | input | 2 | Central multiplicity select |
| gate_len | input | 4 | Coincidence gate length in cycles |
| only_part | input | 1 | Central event reaches only participating channels |
| common_dead | input | 1 | Shared dead-time mode |
| chain_len | input | 64 | Slave count per channel, 4 bits each, 0 = not a master |
| post_trig | input | 3 | Post-trigger delay code; spacing is code+1 cycles |
| pp_en | input | 8 | Ping-pong enable per channel pair |
| l2_en | input | 1 | Enable second-level qualification |
| l2_gate | input | 1 | Second-level gate; must be high for a trigger when enabled |
| rel | input | 16 | Release pulse per channel from conversion logic |
| trig | output | 16 | One-cycle stop-sampling pulse per channel |
| dead | output | 16 | Channel is in dead time |

## Verification
The hardest state to reach is an overlap of modes. A chain must be part way through its slaves while other channels are busy. A ping-pong pair must have its first channel busy exactly when the next pulse arrives. Coincidence gates must close exactly one cycle before a second hit. The stimulus reaches each of these by timing discriminator edges cycle by cycle against the programmed gate length and post-trigger code, and by holding back releases so that busy channels pile up. A behavioural model, run on every clock, follows the same cycles and catches any slip in the order of chain pulses or in pair routing.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  typedef enum logic [1:0] {
    SRC_SELF    = 2'd0,
    SRC_CENTRAL = 2'd1,
    SRC_EXT     = 2'd2,
    SRC_NONE    = 2'd3
  } trig_src_e;

  // number of open gates required for a central event
  function automatic int unsigned need_count(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 3;
    endcase
  endfunction

  // population count over a zero-extended vector
  function automatic int unsigned ones(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 64; k++) n += int'(v[k]);
    return n;
  endfunction

endpackage

// File: rtl/ct_edge_gate.sv
module ct_edge_gate #(
  parameter int NCH = 16,
  parameter int GW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] disc,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ct_part,
  input  logic [NCH-1:0] edge_fall,
  input  logic [NCH-1:0] dead,
  input  logic [GW-1:0]  gate_len,
  output logic [NCH-1:0] hit,
  output logic [NCH-1:0] gate_open
);

  logic [GW-1:0] reload;
  assign reload = (gate_len == '0) ? '0 : gate_len - 1'b1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          prev;
    logic [GW-1:0] rem;
    logic          part_hit;

    assign hit[g]       = ch_en[g] & (edge_fall[g] ? (prev & ~disc[g]) : (~prev & disc[g]));
    assign part_hit     = hit[g] & ct_part[g] & ~dead[g];
    assign gate_open[g] = part_hit | (rem != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev <= 1'b0;
        rem  <= '0;
      end else begin
        prev <= disc[g];
        if (part_hit)        rem <= reload;
        else if (rem != '0)  rem <= rem - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ct_judge.sv
module ct_judge #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] gate_open,
  input  logic [1:0]     mult_sel,
  output logic           ct_evt
);
  import coinc_pkg::*;

  logic cond, cond_q;

  always_comb begin
    cond = ones(64'(gate_open)) >= need_count(mult_sel);
  end

  assign ct_evt = cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

endmodule

// File: rtl/ct_chain.sv
module ct_chain #(
  parameter int NCH = 16,
  parameter int CW  = 4,
  parameter int PW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  fire,
  input  logic [NCH*CW-1:0] chain_len,
  input  logic [PW-1:0]   post_trig,
  output logic [NCH-1:0]  chain_hit
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          active;
  logic [IW-1:0] cur;
  logic [CW-1:0] left;
  logic [PW-1:0] tmr;
  logic          m_found;
  logic [IW-1:0] m_idx;
  logic [CW-1:0] m_len;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] c);
    return (c == IW'(NCH - 1)) ? '0 : c + 1'b1;
  endfunction

  // lowest-index master among the channels firing now
  always_comb begin
    m_found = 1'b0;
    m_idx   = '0;
    m_len   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (fire[i] && chain_len[i*CW +: CW] != '0) begin
        m_found = 1'b1;
        m_idx   = IW'(i);
        m_len   = chain_len[i*CW +: CW];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      chain_hit[i] = active && (tmr == '0) && (cur == IW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur    <= '0;
      left   <= '0;
      tmr    <= '0;
    end else if (!active) begin
      if (m_found) begin
        active <= 1'b1;
        cur    <= nxt(m_idx);
        left   <= m_len;
        tmr    <= post_trig;
      end
    end else if (tmr == '0) begin
      cur  <= nxt(cur);
      tmr  <= post_trig;
      left <= left - 1'b1;
      if (left == CW'(1)) active <= 1'b0;
    end else begin
      tmr <= tmr - 1'b1;
    end
  end

endmodule

// File: rtl/coinc_trig.sv
module coinc_trig #(
  parameter int NCH = 16,
  parameter int GW  = 4,
  parameter int CW  = 4,
  parameter int PW  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      disc,
  input  logic [NCH-1:0]      ch_en,
  input  logic [NCH-1:0]      ct_part,
  input  logic [NCH-1:0]      edge_fall,
  input  logic [2*NCH-1:0]    src_sel,
  input  logic                ext_trig,
  input  logic [1:0]          mult_sel,
  input  logic [GW-1:0]       gate_len,
  input  logic                only_part,
  input  logic                common_dead,
  input  logic [NCH*CW-1:0]   chain_len,
  input  logic [PW-1:0]       post_trig,
  input  logic [NCH/2-1:0]    pp_en,
  input  logic                l2_en,
  input  logic                l2_gate,
  input  logic [NCH-1:0]      rel,
  output logic [NCH-1:0]      trig,
  output logic [NCH-1:0]      dead
);
  import coinc_pkg::*;

  localparam int NPAIR = NCH / 2;

  // named internal events
  logic [NCH-1:0] busy;
  logic [NCH-1:0] avail;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] gate_open;
  logic [NCH-1:0] req;
  logic [NCH-1:0] take;
  logic [NCH-1:0] chain_hit;
  logic [NCH-1:0] chain_take;
  logic [NCH-1:0] fire;
  logic           ct_evt;
  logic           ext_q;
  logic           ext_evt;
  logic           l2_ok;

  assign dead    = busy | {NCH{common_dead & (|busy)}};
  assign avail   = ch_en & ~dead;
  assign ext_evt = ext_trig & ~ext_q;
  assign l2_ok   = ~l2_en | l2_gate;

  ct_edge_gate #(.NCH(NCH), .GW(GW)) i_edge_gate (
    .clk(clk), .rst_n(rst_n), .disc(disc), .ch_en(ch_en), .ct_part(ct_part),
    .edge_fall(edge_fall), .dead(dead), .gate_len(gate_len),
    .hit(hit), .gate_open(gate_open)
  );

  ct_judge #(.NCH(NCH)) i_judge (
    .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .mult_sel(mult_sel), .ct_evt(ct_evt)
  );

  ct_chain #(.NCH(NCH), .CW(CW), .PW(PW)) i_chain (
    .clk(clk), .rst_n(rst_n), .fire(fire), .chain_len(chain_len),
    .post_trig(post_trig), .chain_hit(chain_hit)
  );

  // per-channel request from the selected source
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      case (trig_src_e'(src_sel[i*2 +: 2]))
        SRC_SELF:    req[i] = hit[i];
        SRC_CENTRAL: req[i] = ct_evt & (~only_part | gate_open[i]);
        SRC_EXT:     req[i] = ext_evt;
        default:     req[i] = 1'b0;
      endcase
      req[i] = req[i] & ch_en[i];
    end
  end

  // pair routing
  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic preq;
    assign preq = req[2*k] | req[2*k+1];
    always_comb begin
      if (pp_en[k]) begin
        take[2*k]   = preq & avail[2*k];
        take[2*k+1] = preq & ~avail[2*k] & avail[2*k+1];
      end else begin
        take[2*k]   = req[2*k]   & avail[2*k];
        take[2*k+1] = req[2*k+1] & avail[2*k+1];
      end
    end
  end

  if (NCH % 2 != 0) begin : g_odd
    assign take[NCH-1] = req[NCH-1] & avail[NCH-1];
  end

  assign chain_take = chain_hit & ch_en & ~busy;
  assign fire       = {NCH{l2_ok}} & (take | chain_take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= '0;
      trig  <= '0;
      ext_q <= 1'b0;
    end else begin
      busy  <= (busy & ~rel) | fire;
      trig  <= fire;
      ext_q <= ext_trig;
    end
  end

endmodule

// File: rtl/coinc_trig_chk.sv
module coinc_trig_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] rel,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] trig,
  input logic [NCH-1:0] busy,
  input logic           l2_en,
  input logic           l2_gate
);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(busy) & ~$past(rel)) & ~busy) == '0));

  // R3
  trig_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig & $past(busy)) == '0));

  // R2
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig & $past(trig)) == '0));

  // R12
  trig_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig & ~$past(ch_en)) == '0));

  // R11
  l2_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_en && !l2_gate) |=> (trig == '0));

endmodule

bind coinc_trig coinc_trig_chk #(.NCH(NCH)) i_chk (
  .clk(clk), .rst_n(rst_n), .rel(rel), .ch_en(ch_en), .trig(trig),
  .busy(busy), .l2_en(l2_en), .l2_gate(l2_gate)
);

// File: tb/test_coinc_trig.sv
module test_coinc_trig;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  disc = '0, ch_en = '1, ct_part = '0, edge_fall = '0, rel = '0;
  logic [2*N-1:0] src_sel = '1;
  logic          ext_trig = 1'b0;
  logic [1:0]    mult_sel = 2'd0;
  logic [3:0]    gate_len = 4'd4;
  logic          only_part = 1'b0, common_dead = 1'b0;
  logic [4*N-1:0] chain_len = '0;
  logic [2:0]    post_trig = 3'd0;
  logic [N/2-1:0] pp_en = '0;
  logic          l2_en = 1'b0, l2_gate = 1'b0;
  logic [N-1:0]  trig, dead;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  coinc_trig i_coinc_trig (
    .clk(clk), .rst_n(rst_n), .disc(disc), .ch_en(ch_en), .ct_part(ct_part),
    .edge_fall(edge_fall), .src_sel(src_sel), .ext_trig(ext_trig), .mult_sel(mult_sel),
    .gate_len(gate_len), .only_part(only_part), .common_dead(common_dead),
    .chain_len(chain_len), .post_trig(post_trig), .pp_en(pp_en), .l2_en(l2_en),
    .l2_gate(l2_gate), .rel(rel), .trig(trig), .dead(dead)
  );

  // ---------------- behavioural reference model ----------------
  int  m_prev[N], m_rem[N];
  bit  m_busy[N];
  bit  m_condq, m_extq, m_act;
  int  m_cur, m_left, m_tmr;
  logic [N-1:0] exp_trig = '0;

  always @(posedge clk) begin : model
    bit h, part, anyb, cev, eev, ok, pr;
    bit dd[N], open[N], rq[N], av[N], f[N];
    int cnt, need, src;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_prev[i] = 0; m_rem[i] = 0; m_busy[i] = 0; end
      m_condq = 0; m_extq = 0; m_act = 0; m_cur = 0; m_left = 0; m_tmr = 0;
      exp_trig = '0;
    end else begin
      anyb = 0;
      for (int i = 0; i < N; i++) anyb |= m_busy[i];
      cnt = 0;
      for (int i = 0; i < N; i++) begin
        dd[i] = m_busy[i] || (common_dead && anyb);
        h = ch_en[i] && (edge_fall[i] ? (m_prev[i] == 1 && disc[i] == 0)
                                      : (m_prev[i] == 0 && disc[i] == 1));
        part = h && ct_part[i] && !dd[i];
        open[i] = part || (m_rem[i] > 0);
        if (open[i]) cnt++;
        rq[i] = h;  // stash the edge
        m_prev[i] = disc[i];
        if (part) m_rem[i] = (gate_len == 0) ? 0 : int'(gate_len) - 1;
        else if (m_rem[i] > 0) m_rem[i]--;
      end
      need = (mult_sel == 0) ? 1 : (mult_sel == 1) ? 2 : 3;
      cev = (cnt >= need) && !m_condq;
      m_condq = (cnt >= need);
      eev = ext_trig && !m_extq;
      m_extq = ext_trig;
      for (int i = 0; i < N; i++) begin
        src = int'(src_sel[2*i +: 2]);
        if (src == 0)      rq[i] = rq[i];
        else if (src == 1) rq[i] = cev && (!only_part || open[i]);
        else if (src == 2) rq[i] = eev;
        else               rq[i] = 0;
        rq[i] = rq[i] && ch_en[i];
        av[i] = ch_en[i] && !dd[i];
      end
      ok = !l2_en || l2_gate;
      for (int k = 0; k < N/2; k++) begin
        if (pp_en[k]) begin
          pr = rq[2*k] || rq[2*k+1];
          f[2*k]   = pr && av[2*k];
          f[2*k+1] = pr && !av[2*k] && av[2*k+1];
        end else begin
          f[2*k]   = rq[2*k] && av[2*k];
          f[2*k+1] = rq[2*k+1] && av[2*k+1];
        end
      end
      for (int i = 0; i < N; i++) begin
        if (m_act && m_tmr == 0 && i == m_cur && ch_en[i] && !m_busy[i]) f[i] = 1;
        f[i] = f[i] && ok;
        exp_trig[i] = f[i];
        m_busy[i] = (m_busy[i] && !rel[i]) || f[i];
      end
      if (!m_act) begin
        for (int i = N - 1; i >= 0; i--)
          if (f[i] && chain_len[4*i +: 4] != 0) begin
            m_act = 1; m_cur = (i + 1) % N; m_left = int'(chain_len[4*i +: 4]);
            m_tmr = int'(post_trig);
          end
      end else if (m_tmr == 0) begin
        m_cur = (m_cur + 1) % N; m_tmr = int'(post_trig); m_left--;
        if (m_left == 0) m_act = 0;
      end else m_tmr--;
    end
  end

  // compare on every clock, half a period after the edge
  always @(negedge clk) begin : cmp
    logic [N-1:0] ed;
    bit anyb;
    if (rst_n && !done) begin
      anyb = 0;
      for (int i = 0; i < N; i++) anyb |= m_busy[i];
      for (int i = 0; i < N; i++) ed[i] = m_busy[i] || (common_dead && anyb);
      checks++;
      if (trig !== exp_trig || dead !== ed) begin
        errors++;
        $display("FAIL %s model: trig %h dead %h expected trig %h dead %h",
                 phase, trig, dead, exp_trig, ed);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #(Q);
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic set_src(input int ch, input logic [1:0] v);
    src_sel[2*ch +: 2] = v;
  endtask

  task automatic release_all();
    disc = '0;
    rel = '1;
    tick();
    rel = '0;
    tick(6);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    #(Q);
    chk("R1 trig", trig, '0);
    chk("R1 dead", dead, '0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 trig after reset", trig, '0);
    chk("R1 dead after reset", dead, '0);

    // R2 self trigger, rising edge
    phase = "R2";
    set_src(0, 2'd0);
    disc[0] = 1'b1; tick();
    chk("R2 rising pulse", trig, 16'h0001);
    chk("R3 dead after trig", dead, 16'h0001);
    tick();
    chk("R2 single pulse", trig, 16'h0000);

    // R3 ignore while dead, then release
    phase = "R3";
    disc[0] = 1'b0; tick();
    disc[0] = 1'b1; tick();
    chk("R3 ignored while dead", trig, 16'h0000);
    chk("R3 still dead", dead, 16'h0001);
    rel[0] = 1'b1; tick(); rel[0] = 1'b0;
    chk("R3 freed by release", dead, 16'h0000);
    disc[0] = 1'b0; tick();
    disc[0] = 1'b1; tick();
    chk("R3 rearmed", trig, 16'h0001);
    release_all();

    // R2 falling edge
    phase = "R2";
    set_src(1, 2'd0); edge_fall[1] = 1'b1;
    disc[1] = 1'b1; tick();
    chk("R2 no trig on rising when falling selected", trig, 16'h0000);
    disc[1] = 1'b0; tick();
    chk("R2 falling pulse", trig, 16'h0002);
    edge_fall[1] = 1'b0; set_src(0, 2'd3); set_src(1, 2'd3);
    release_all();

    // R4 coincidence of two within gate
    phase = "R4";
    set_src(2, 2'd1); set_src(3, 2'd1);
    ct_part[4] = 1'b1; ct_part[5] = 1'b1;
    mult_sel = 2'd1; gate_len = 4'd3;
    disc[4] = 1'b1; tick();
    chk("R4 one hit alone", trig, 16'h0000);
    tick();
    disc[5] = 1'b1; tick();
    chk("R4 two hits in gate", trig, 16'h000C);
    release_all();
    disc[4] = 1'b1; tick(3);
    disc[5] = 1'b1; tick();
    chk("R4 hits outside gate", trig, 16'h0000);
    release_all();

    // R5 threshold three
    phase = "R5";
    mult_sel = 2'd2; ct_part[6] = 1'b1;
    disc[4] = 1'b1; tick();
    disc[5] = 1'b1; tick();
    chk("R5 two of three", trig, 16'h0000);
    disc[6] = 1'b1; tick();
    chk("R5 three hits", trig, 16'h000C);
    release_all();

    // R6 participating only
    phase = "R6";
    ct_part = '0; ct_part[4] = 1'b1; mult_sel = 2'd0; only_part = 1'b1;
    set_src(3, 2'd3); set_src(4, 2'd1);
    disc[4] = 1'b1; tick();
    chk("R6 only participating", trig, 16'h0010);
    release_all();
    only_part = 1'b0;
    disc[4] = 1'b1; tick();
    chk("R6 all central channels", trig, 16'h0014);
    release_all();
    set_src(2, 2'd3); set_src(4, 2'd3); ct_part = '0;

    // R7 external trigger, R12 disabled channel
    phase = "R7";
    set_src(7, 2'd2); set_src(8, 2'd2); ch_en[8] = 1'b0;
    ext_trig = 1'b1; tick();
    chk("R7 external edge, R12 disabled skipped", trig, 16'h0080);
    tick();
    chk("R7 level held", trig, 16'h0000);
    ext_trig = 1'b0;
    phase = "R12";
    ch_en[9] = 1'b0; set_src(9, 2'd0);
    disc[9] = 1'b1; tick();
    chk("R12 disabled self", trig, 16'h0000);
    chk("R12 disabled not dead", dead & 16'h0200, 16'h0000);
    ch_en = '1; set_src(7, 2'd3); set_src(8, 2'd3); set_src(9, 2'd3);
    release_all();

    // R8 common dead time
    phase = "R8";
    common_dead = 1'b1;
    set_src(10, 2'd0); set_src(11, 2'd0);
    disc[10] = 1'b1; tick();
    chk("R8 first trig", trig, 16'h0400);
    chk("R8 all dead", dead, 16'hFFFF);
    disc[11] = 1'b1; tick();
    chk("R8 second ignored", trig, 16'h0000);
    rel[10] = 1'b1; tick(); rel[10] = 1'b0;
    chk("R8 released", dead, 16'h0000);
    common_dead = 1'b0; set_src(10, 2'd3); set_src(11, 2'd3);
    release_all();

    // R9 chain of three slaves, spacing three cycles
    phase = "R9";
    set_src(12, 2'd0); chain_len[12*4 +: 4] = 4'd3; post_trig = 3'd2;
    disc[12] = 1'b1; tick();
    chk("R9 master", trig, 16'h1000);
    tick(2);
    chk("R9 gap", trig, 16'h0000);
    tick();
    chk("R9 slave 13", trig, 16'h2000);
    tick(3);
    chk("R9 slave 14", trig, 16'h4000);
    tick(3);
    chk("R9 slave 15", trig, 16'h8000);
    tick(3);
    chk("R9 chain ended", trig, 16'h0000);
    chain_len = '0; set_src(12, 2'd3); post_trig = 3'd0;
    release_all();

    // R10 ping-pong on pair 0
    phase = "R10";
    pp_en[0] = 1'b1; set_src(0, 2'd0);
    disc[0] = 1'b1; tick();
    chk("R10 first to even", trig, 16'h0001);
    disc[0] = 1'b0; tick();
    disc[0] = 1'b1; tick();
    chk("R10 second to odd", trig, 16'h0002);
    disc[0] = 1'b0; tick();
    disc[0] = 1'b1; tick();
    chk("R10 both busy", trig, 16'h0000);
    pp_en = '0;
    release_all();

    // R11 second-level veto
    phase = "R11";
    l2_en = 1'b1; l2_gate = 1'b0;
    disc[0] = 1'b1; tick();
    chk("R11 vetoed", trig, 16'h0000);
    chk("R11 not dead", dead, 16'h0000);
    disc[0] = 1'b0; tick();
    l2_gate = 1'b1;
    disc[0] = 1'b1; tick();
    chk("R11 qualified", trig, 16'h0001);
    l2_en = 1'b0;
    release_all();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule